// File: doc/BRIEF.md
# Indirect-Addressed Byte Memory Port with Lockable Windows

This block sits between a narrow, four-slot byte port and a byte-wide memory with a 16-bit address space. The port side never presents a full address. Software first loads an internal address latch one byte at a time through two address slots. It then moves data through a single data slot. A data write stores the byte at the latched address and returns the latch to zero. A data read fetches the byte at the latched address and leaves the latch as it was, so repeated reads of one location need no reloading.

Two lock bits guard two consecutive 16-byte windows, at 0x20..0x2F and 0x30..0x3F. While a window is locked, data writes aimed at it never reach the memory, and data reads from it return all-ones. Each lock bit changes state only when a toggle request names it. Any address at or beyond the configured memory size is handled the same way as a locked address. The memory side is a simple request port: the request, write enable, address and write data are driven combinationally in the cycle of the port strobe, and read data is expected one cycle after a read request.

Top module: `nvport_bridge`

## Requirements
- R1: A write to slot 0 replaces the low byte of the address latch, and a write to slot 1 replaces the high byte. In both cases the other byte keeps its value, and no memory request is made.
- R2: A write to slot 3 issues a memory write in the same cycle, carrying its data at the latched address. From the next cycle the latch holds 0x0000.
- R3: A read of slot 3 issues a memory read in the same cycle at the latched address. In the following cycle port_rvalid is 1 and port_rdata carries the byte the memory returned. The latch is not changed.
- R4: A read of slot 0, 1 or 2 makes no memory request and gives port_rvalid=1 with port_rdata=0xFF one cycle later. A write to slot 2 makes no request and leaves the latch unchanged.
- R5: Lock bit 0 guards addresses 0x20..0x2F and lock bit 1 guards 0x30..0x3F. While a window is locked, a slot-3 write to it makes no memory request but still clears the latch, and a slot-3 read from it makes no request and returns 0xFF.
- R6: A cycle with lock_toggle_vld=1 inverts the lock bit whose index is on lock_toggle_sel, and leaves the other bit as it was. An access in the same cycle as the toggle sees the old lock state.
- R7: A slot-3 access whose latched address is at or above MEM_SIZE makes no memory request. A read of this kind returns 0xFF, and a write still clears the latch.
- R8: After reset the latch is 0x0000, both windows are unlocked and port_rvalid is 0.
- R9: When port_wr and port_rd are both high in one cycle, only the write takes effect, and port_rvalid stays 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_sel | input | 2 | Slot select: 0 address low, 1 address high, 2 spare, 3 data |
| port_wr | input | 1 | Write strobe, one cycle per access |
| port_rd | input | 1 | Read strobe, one cycle per access |
| port_wdata | input | 8 | Write data byte |
| port_rdata | output | 8 | Read data byte, valid with port_rvalid |
| port_rvalid | output | 1 | Read response valid, one cycle after port_rd |
| lock_toggle_vld | input | 1 | Request to invert one lock bit |
| lock_toggle_sel | input | 1 | Index of the lock bit to invert |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable, meaningful with mem_req |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after a read request |

## Verification
The memory request is checked in the cycle of the strobe itself. It is sampled after the inputs settle and before the rising edge, because request, write enable, address and write data come from the strobe and the current latch without any register in between. The read response passes through one register stage, plus the one-cycle memory model in the bench. port_rvalid and port_rdata are therefore sampled just after the edge that ends the strobe cycle. Latch and lock updates are not visible at the ports directly. They are checked through the address, the request and the read data of the next slot-3 access, which the bench reference model predicts from its own copy of latch, locks and memory.

// File: rtl/nvport_pkg.sv
// Shared definitions for the indirect-addressed memory port.
// Assumes a two-bit slot select on the port side.
package nvport_pkg;

    typedef enum logic [1:0] {
        SLOT_ADDR_LO = 2'd0,
        SLOT_ADDR_HI = 2'd1,
        SLOT_SPARE   = 2'd2,
        SLOT_DATA    = 2'd3
    } slot_e;

endpackage

// File: rtl/nvport_addr_latch.sv
// Address latch loaded one byte at a time.
// Assumes ADDR_W > DATA_W. The low part is DATA_W bits and the high part takes the rest.
// The load strobes and the clear strobe never arrive together, because they come from different slots.
module nvport_addr_latch #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic              clr,
    input  logic [DATA_W-1:0] byte_in,
    output logic [ADDR_W-1:0] addr_q
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic [HI_W-1:0] hi_byte;
    assign hi_byte = byte_in[HI_W-1:0];

    // Holds the latch; clears on reset and after a data write, otherwise loads one part.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (clr) begin
            addr_q <= '0;
        end else if (lo_we) begin
            addr_q[DATA_W-1:0] <= byte_in;
        end else if (hi_we) begin
            addr_q[ADDR_W-1:DATA_W] <= hi_byte;
        end
    end

    // R2
    latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> addr_q == '0);

    // R1
    lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_we && !clr) |=> (addr_q[DATA_W-1:0] == $past(byte_in)) &&
                            (addr_q[ADDR_W-1:DATA_W] == $past(addr_q[ADDR_W-1:DATA_W])));

    // R1
    hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_we && !lo_we && !clr) |=> (addr_q[DATA_W-1:0] == $past(addr_q[DATA_W-1:0])));

endmodule

// File: rtl/nvport_lock_ctrl.sv
// Lock bits and window decode.
// Window i covers LOCK_BASE + i*LOCK_SPAN up to, but not including, LOCK_BASE + (i+1)*LOCK_SPAN.
// Assumes NUM_LOCKS >= 2. A toggle index at or above NUM_LOCKS is ignored.
module nvport_lock_ctrl #(
    parameter int          ADDR_W    = 16,
    parameter int          NUM_LOCKS = 2,
    parameter int unsigned LOCK_BASE = 32'h20,
    parameter int unsigned LOCK_SPAN = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tgl_vld,
    input  logic [$clog2(NUM_LOCKS)-1:0] tgl_sel,
    input  logic [ADDR_W-1:0]            addr,
    output logic                         addr_locked
);
    logic [NUM_LOCKS-1:0] lock_q;
    logic [NUM_LOCKS-1:0] win_hit;
    logic [NUM_LOCKS-1:0] tgl_mask;
    logic [31:0]          addr_ext;

    assign addr_ext = 32'(addr);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_LOCKS; gi++) begin : g_win
            localparam int unsigned WLO = LOCK_BASE + gi * LOCK_SPAN;
            localparam int unsigned WHI = WLO + LOCK_SPAN;
            // Flags whether the address falls inside window gi.
            assign win_hit[gi]  = (addr_ext >= WLO) && (addr_ext < WHI);
            // Flags whether the toggle request names lock bit gi.
            assign tgl_mask[gi] = tgl_vld && (32'(tgl_sel) == gi);
        end
    endgenerate

    // Inverts the named lock bits; reset unlocks every window.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= '0;
        else        lock_q <= lock_q ^ tgl_mask;
    end

    assign addr_locked = |(win_hit & lock_q);

    // R6
    lock_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgl_vld && (32'(tgl_sel) < NUM_LOCKS)) |=> $countones(lock_q ^ $past(lock_q)) == 1);

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tgl_vld |=> $stable(lock_q));

endmodule

// File: rtl/nvport_access_ctrl.sv
// Slot decode, memory request generation and read response.
// Assumes a memory that returns read data one cycle after the request.
// When both strobes are high, the write takes priority.
module nvport_access_ctrl
    import nvport_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int unsigned MEM_SIZE = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        port_sel,
    input  logic              port_wr,
    input  logic              port_rd,
    input  logic [DATA_W-1:0] port_wdata,
    output logic [DATA_W-1:0] port_rdata,
    output logic              port_rvalid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_locked,
    output logic              lo_we,
    output logic              hi_we,
    output logic              clr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic do_wr, do_rd, is_data, in_range, permit;
    logic resp_vld_q, resp_ones_q;

    // Decodes the strobe and slot into latch controls and a memory request.
    always_comb begin
        do_wr    = port_wr;
        do_rd    = port_rd && !port_wr;
        is_data  = (port_sel == SLOT_DATA);
        in_range = (32'(addr) < MEM_SIZE);
        permit   = in_range && !addr_locked;
        lo_we    = do_wr && (port_sel == SLOT_ADDR_LO);
        hi_we    = do_wr && (port_sel == SLOT_ADDR_HI);
        clr      = do_wr && is_data;
        mem_req  = (do_wr || do_rd) && is_data && permit;
        mem_we   = do_wr;
        mem_addr = addr;
        mem_wdata = port_wdata;
    end

    // Records a pending read response and whether it must read as all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_vld_q  <= 1'b0;
            resp_ones_q <= 1'b1;
        end else begin
            resp_vld_q  <= do_rd;
            resp_ones_q <= !(is_data && permit);
        end
    end

    assign port_rvalid = resp_vld_q;
    assign port_rdata  = resp_ones_q ? '1 : mem_rdata;

    // R3
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && !port_wr) |=> port_rvalid);

    // R9
    write_no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |=> !port_rvalid);

    // R7
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (32'(mem_addr) < MEM_SIZE));

    // R4
    slot_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (port_sel == SLOT_DATA) && (port_wr || port_rd));

endmodule

// File: rtl/nvport_bridge.sv
// Top level of the indirect-addressed byte memory port with two lockable windows.
// It joins the address latch, the lock control and the access control.
// Assumes single-cycle strobes and a memory with one cycle of read latency.
module nvport_bridge #(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter int unsigned MEM_SIZE  = 1024,
    parameter int          NUM_LOCKS = 2,
    parameter int unsigned LOCK_BASE = 32'h20,
    parameter int unsigned LOCK_SPAN = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   port_sel,
    input  logic                         port_wr,
    input  logic                         port_rd,
    input  logic [DATA_W-1:0]            port_wdata,
    output logic [DATA_W-1:0]            port_rdata,
    output logic                         port_rvalid,
    input  logic                         lock_toggle_vld,
    input  logic [$clog2(NUM_LOCKS)-1:0] lock_toggle_sel,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic [DATA_W-1:0]            mem_wdata,
    input  logic [DATA_W-1:0]            mem_rdata
);
    logic [ADDR_W-1:0] addr_q;
    logic              addr_locked;
    logic              lo_we, hi_we, clr;

    nvport_addr_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_we   (lo_we),
        .hi_we   (hi_we),
        .clr     (clr),
        .byte_in (port_wdata),
        .addr_q  (addr_q)
    );

    nvport_lock_ctrl #(
        .ADDR_W    (ADDR_W),
        .NUM_LOCKS (NUM_LOCKS),
        .LOCK_BASE (LOCK_BASE),
        .LOCK_SPAN (LOCK_SPAN)
    ) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .tgl_vld     (lock_toggle_vld),
        .tgl_sel     (lock_toggle_sel),
        .addr        (addr_q),
        .addr_locked (addr_locked)
    );

    nvport_access_ctrl #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .MEM_SIZE (MEM_SIZE)
    ) u_access (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_sel    (port_sel),
        .port_wr     (port_wr),
        .port_rd     (port_rd),
        .port_wdata  (port_wdata),
        .port_rdata  (port_rdata),
        .port_rvalid (port_rvalid),
        .addr        (addr_q),
        .addr_locked (addr_locked),
        .lo_we       (lo_we),
        .hi_we       (hi_we),
        .clr         (clr),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata)
    );

    // R5
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> port_wr && !addr_locked);

endmodule

// File: tb/nvport_bridge_tb_top.sv
module nvport_bridge_tb_top;
    localparam int MEM = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] port_sel = 2'd0;
    logic       port_wr = 1'b0, port_rd = 1'b0;
    logic [7:0] port_wdata = 8'h00;
    logic [7:0] port_rdata;
    logic       port_rvalid;
    logic       lock_toggle_vld = 1'b0;
    logic [0:0] lock_toggle_sel = 1'b0;
    logic       mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = 8'h00;

    int checks = 0;
    int failures = 0;

    logic [7:0]  mem_model [MEM];
    logic [7:0]  shadow [MEM];
    logic [15:0] exp_latch = 16'h0;
    logic [1:0]  exp_lock = 2'b00;

    always #2.5 clk = ~clk;

    nvport_bridge #(.MEM_SIZE(MEM)) dut_i (
        .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .port_wr(port_wr),
        .port_rd(port_rd), .port_wdata(port_wdata), .port_rdata(port_rdata),
        .port_rvalid(port_rvalid), .lock_toggle_vld(lock_toggle_vld),
        .lock_toggle_sel(lock_toggle_sel), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Simple memory with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_req && mem_we) mem_model[mem_addr[8:0]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem_model[mem_addr[8:0]];
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit is_locked(input logic [15:0] a, input logic [1:0] lk);
        return (lk[0] && a >= 16'h20 && a <= 16'h2F) ||
               (lk[1] && a >= 16'h30 && a <= 16'h3F);
    endfunction

    // One port cycle: drive, check the request before the edge, check the response after it.
    task automatic step(input logic [1:0] s, input logic w, input logic r,
                        input logic [7:0] d, input logic tv, input logic ts,
                        input string tag_in);
        logic [15:0] a;
        bit allowed, exp_req, exp_rv;
        logic [7:0] exp_rd;
        string tag;
        @(negedge clk);
        port_sel = s; port_wr = w; port_rd = r; port_wdata = d;
        lock_toggle_vld = tv; lock_toggle_sel = ts;
        #1;
        a = exp_latch;
        allowed = (s == 2'd3) && (a < MEM) && !is_locked(a, exp_lock);
        exp_req = (w || r) && allowed;
        exp_rv  = r && !w;
        exp_rd  = allowed ? shadow[a[8:0]] : 8'hFF;
        if (tag_in != "")            tag = tag_in;
        else if (w && r)             tag = "R9";
        else if (s != 2'd3)          tag = (w && s != 2'd2) ? "R1" : "R4";
        else if (a >= MEM)           tag = "R7";
        else if (is_locked(a, exp_lock)) tag = "R5";
        else if (w)                  tag = "R2";
        else                         tag = "R3";
        chk(mem_req == exp_req, tag, "mem_req", int'(mem_req), int'(exp_req));
        if (exp_req) begin
            chk(mem_addr == a, tag, "mem_addr", int'(mem_addr), int'(a));
            chk(mem_we == w, tag, "mem_we", int'(mem_we), int'(w));
            if (w) chk(mem_wdata == d, tag, "mem_wdata", int'(mem_wdata), int'(d));
        end
        if (w) begin
            case (s)
                2'd0: exp_latch[7:0]  = d;
                2'd1: exp_latch[15:8] = d;
                2'd3: begin
                    if (allowed) shadow[a[8:0]] = d;
                    exp_latch = 16'h0;
                end
                default: ;
            endcase
        end
        if (tv) exp_lock[ts] = ~exp_lock[ts];
        @(posedge clk);
        #1;
        chk(port_rvalid == exp_rv, tag, "port_rvalid", int'(port_rvalid), int'(exp_rv));
        if (exp_rv) chk(port_rdata == exp_rd, tag, "port_rdata", int'(port_rdata), int'(exp_rd));
    endtask

    task automatic set_addr(input logic [15:0] a, input string tag);
        step(2'd0, 1'b1, 1'b0, a[7:0], 1'b0, 1'b0, tag);
        step(2'd1, 1'b1, 1'b0, a[15:8], 1'b0, 1'b0, tag);
    endtask

    task automatic rd3(input string tag);
        step(2'd3, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, tag);
    endtask

    task automatic wr3(input logic [7:0] d, input string tag);
        step(2'd3, 1'b1, 1'b0, d, 1'b0, 1'b0, tag);
    endtask

    task automatic toggle(input logic ts);
        step(2'd2, 1'b0, 1'b0, 8'h00, 1'b1, ts, "R6");
    endtask

    initial begin : watchdog
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog timeout actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < MEM; i++) begin
            mem_model[i] = 8'(i * 7 + 3);
            shadow[i]    = 8'(i * 7 + 3);
        end
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1;
        chk(port_rvalid == 1'b0, "R8", "rvalid in reset", int'(port_rvalid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(port_rvalid == 1'b0, "R8", "rvalid after reset", int'(port_rvalid), 0);
        // R8: latch starts at zero and windows start unlocked.
        rd3("R8");
        set_addr(16'h0020, "R8");
        wr3(8'hA5, "R8");
        set_addr(16'h0020, "R8");
        rd3("R8");
        // R1: each address byte replaced separately.
        set_addr(16'h0134, "R1");
        rd3("R1");
        step(2'd0, 1'b1, 1'b0, 8'h56, 1'b0, 1'b0, "R1");
        rd3("R1");
        step(2'd1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R1");
        rd3("R1");
        // R3: reads leave the latch alone.
        rd3("R3");
        // R2: write stores data and clears the latch.
        set_addr(16'h0105, "R2");
        wr3(8'h3C, "R2");
        rd3("R2");
        set_addr(16'h0105, "R2");
        rd3("R2");
        // R4: spare slot write ignored; address slot reads return all-ones.
        step(2'd2, 1'b1, 1'b0, 8'h77, 1'b0, 1'b0, "R4");
        rd3("R4");
        for (int sl = 0; sl < 3; sl++) step(2'(sl), 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, "R4");
        // R5: lock windows and their edges.
        toggle(1'b0);
        set_addr(16'h0025, "R5"); wr3(8'h11, "R5");
        rd3("R5");
        set_addr(16'h0025, "R5"); rd3("R5");
        set_addr(16'h002F, "R5"); rd3("R5");
        set_addr(16'h001F, "R5"); rd3("R5");
        set_addr(16'h0030, "R5"); wr3(8'h22, "R5");
        set_addr(16'h0030, "R5"); rd3("R5");
        toggle(1'b1);
        set_addr(16'h003F, "R5"); rd3("R5"); wr3(8'h33, "R5");
        set_addr(16'h003F, "R5"); rd3("R5");
        set_addr(16'h0040, "R5"); rd3("R5");
        // R6: toggle in the same cycle as an access uses the old state.
        set_addr(16'h0021, "R6");
        step(2'd3, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, "R6");
        rd3("R6");
        step(2'd3, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1, "R6");
        set_addr(16'h0031, "R6"); rd3("R6");
        // R7: beyond memory size.
        set_addr(16'h0200, "R7"); rd3("R7"); wr3(8'h44, "R7"); rd3("R7");
        set_addr(16'hFFFF, "R7"); rd3("R7");
        set_addr(16'h01FF, "R7"); rd3("R7");
        // R9: both strobes at once.
        set_addr(16'h0010, "R9");
        step(2'd3, 1'b1, 1'b1, 8'h5A, 1'b0, 1'b0, "R9");
        set_addr(16'h0010, "R9"); rd3("R9");
        // Constrained random mix.
        for (int it = 0; it < 2500; it++) begin
            logic [15:0] ta;
            int kind;
            kind = int'($urandom % 4);
            case (kind)
                0: ta = 16'($urandom % 64);
                1: ta = 16'h20 + 16'($urandom % 32);
                2: ta = 16'($urandom % MEM);
                default: ta = 16'(MEM) + 16'($urandom % (65536 - MEM));
            endcase
            if ($urandom % 4 != 0) set_addr(ta, "");
            begin
                logic [1:0] s;
                logic w, r, tv;
                s  = ($urandom % 4 == 0) ? 2'($urandom % 4) : 2'd3;
                w  = 1'($urandom % 2);
                r  = ($urandom % 8 == 0) ? 1'b1 : ~w;
                tv = ($urandom % 8 == 0);
                step(s, w, r, 8'($urandom), tv, 1'($urandom), "");
            end
        end
        @(negedge clk);
        port_wr = 1'b0; port_rd = 1'b0; lock_toggle_vld = 1'b0;
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule